// File: doc/BRIEF.md
# Wait-for-Interrupt Sleep Controller

This block sits beside a core's decode stage and follows it into and out of a low-power wait. It watches the instruction word in decode. When it sees the wait instruction, it raises a wait-state flag. After a fixed drain period it raises a sleep flag, which clock-gating logic outside the block can use to stop the core.

Either of two wake events ends the wait: any pending interrupt that is enabled locally, or a debug request. There is no global interrupt-enable term in the wake condition, so the core wakes whether or not it would go on to take the interrupt. A short time after the wait ends, the block sends a one-cycle strobe that tells the fetch unit to resume. The strobe is suppressed when fetching is disabled or the core is in debug mode.

All pins are plain control and status signals. None carries a data stream, so the block has no valid/ready handshake and no back-pressure.

Top module: `wfi_sleep_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `in_wait`, `core_sleep` and `fetch_resume` are all low.
- R2: A wait instruction is recognised only when `id_valid` is high and all 32 bits of `id_instr` equal 32'h1050_0073. A word that differs in any bit, or a matching word with `id_valid` low, leaves `in_wait` low.
- R3: A matching word is ignored in any cycle in which `ex_branch_taken` is high.
- R4: With no wake event present, `in_wait` rises on the clock edge that samples a recognised wait instruction. It then stays high until a wake event occurs.
- R5: A wake event is any set bit of `irq_pend_en` or a high `dbg_req`. `in_wait` is low after every edge that samples a wake event. This holds even when a recognised wait instruction is sampled on the same edge, so no wait state is entered.
- R6: `core_sleep` rises on the 6th edge (`SLEEP_DELAY`) after the edge at which `in_wait` rose, provided no wake event occurs in between. If a wake event comes during the drain, `core_sleep` never rises for that wait. `core_sleep` is never high while `in_wait` is low.
- R7: While `core_sleep` is high, a wake event makes `core_sleep` and `in_wait` both low after the next edge.
- R8: `fetch_resume` is high for exactly one cycle, after the 2nd edge (`RESUME_LAT`) following the edge at which `in_wait` fell. It is suppressed when, in the cycle before that edge, `fetch_en` is low or `dbg_mode` is high.
- R9: `dbg_mode` alone does not wake the core: a high `dbg_mode` with no wake event keeps both `in_wait` and `core_sleep` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_valid | input | 1 | Decode-stage word is valid |
| id_instr | input | 32 | Decode-stage instruction word |
| ex_branch_taken | input | 1 | Taken branch in execute cancels the decode word |
| irq_pend_en | input | NUM_IRQ | Interrupts that are both pending and locally enabled |
| dbg_req | input | 1 | Debug request |
| dbg_mode | input | 1 | Core is in debug mode |
| fetch_en | input | 1 | Instruction fetch is enabled |
| in_wait | output | 1 | Wait state is active |
| core_sleep | output | 1 | Core may be put to sleep |
| fetch_resume | output | 1 | One-cycle strobe telling the fetch unit to restart |

## Verification
Two events can collide in a single cycle: a wait instruction arriving in decode and a wake event. The bench drives the wait word together with a pending interrupt, and then together with a debug request. It judges the result by checking that `in_wait` stays low and that `core_sleep` never rises. The bench also lands a wake on the exact edge where the drain would complete, to confirm that the sleep set path and the wake path cannot both win.

// File: rtl/wfi_pkg.sv
package wfi_pkg;
  localparam logic [31:0] WAIT_OPCODE = 32'h1050_0073;
endpackage

// File: rtl/wfi_decode.sv
module wfi_decode
  import wfi_pkg::*;
(
  input  logic        id_valid,
  input  logic [31:0] id_instr,
  input  logic        ex_branch_taken,
  output logic        is_wait
);
  // Every bit of the word takes part in the compare.
  always_comb begin
    is_wait = id_valid && (id_instr == WAIT_OPCODE) && !ex_branch_taken;
  end
endmodule

// File: rtl/wfi_wait_fsm.sv
module wfi_wait_fsm #(
  parameter int SLEEP_DELAY = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic is_wait,
  input  logic wake,
  output logic in_wait,
  output logic core_sleep
);
  localparam int CW = $clog2(SLEEP_DELAY + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(SLEEP_DELAY);
  localparam logic [CW-1:0] CNT_LAST = CW'(SLEEP_DELAY - 1);

  logic [CW-1:0] drain_cnt;
  logic          wait_n, sleep_n;
  logic [CW-1:0] cnt_n;

  always_comb begin
    // A wake event takes priority over a new wait instruction.
    wait_n  = !wake && (is_wait || in_wait);
    cnt_n   = !in_wait ? '0 : ((drain_cnt == CNT_MAX) ? drain_cnt : drain_cnt + 1'b1);
    sleep_n = in_wait && !wake && (core_sleep || (drain_cnt == CNT_LAST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_wait    <= 1'b0;
      core_sleep <= 1'b0;
      drain_cnt  <= '0;
    end else begin
      in_wait    <= wait_n;
      core_sleep <= sleep_n;
      drain_cnt  <= cnt_n;
    end
  end

  p_wake_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !in_wait);
  p_sleep_in_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    core_sleep |-> in_wait);
  p_sleep_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_sleep && wake) |=> (!core_sleep && !in_wait));
endmodule

// File: rtl/wfi_resume_pipe.sv
module wfi_resume_pipe #(
  parameter int RESUME_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_wait,
  input  logic fetch_en,
  input  logic dbg_mode,
  output logic fetch_resume
);
  logic                  wait_prev;
  logic                  wait_fell;
  logic [RESUME_LAT-1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_prev <= 1'b0;
    else        wait_prev <= in_wait;
  end

  assign wait_fell = wait_prev && !in_wait;

  for (genvar i = 0; i < RESUME_LAT; i++) begin : g_stage
    logic src;
    if (i == 0) begin : g_head
      assign src = wait_fell;
    end else begin : g_body
      assign src = stage[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[i] <= 1'b0;
      else if (i == RESUME_LAT - 1) stage[i] <= src && fetch_en && !dbg_mode;
      else stage[i] <= src;
    end
  end

  assign fetch_resume = stage[RESUME_LAT-1];

  p_resume_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_resume |=> !fetch_resume);
endmodule

// File: rtl/wfi_sleep_ctrl.sv
module wfi_sleep_ctrl #(
  parameter int NUM_IRQ     = 32,
  parameter int SLEEP_DELAY = 6,
  parameter int RESUME_LAT  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               id_valid,
  input  logic [31:0]        id_instr,
  input  logic               ex_branch_taken,
  input  logic [NUM_IRQ-1:0] irq_pend_en,
  input  logic               dbg_req,
  input  logic               dbg_mode,
  input  logic               fetch_en,
  output logic               in_wait,
  output logic               core_sleep,
  output logic               fetch_resume
);
  logic is_wait;
  logic wake;

  assign wake = (|irq_pend_en) || dbg_req;

  wfi_decode u_decode (
    .id_valid        (id_valid),
    .id_instr        (id_instr),
    .ex_branch_taken (ex_branch_taken),
    .is_wait         (is_wait)
  );

  wfi_wait_fsm #(.SLEEP_DELAY(SLEEP_DELAY)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .is_wait    (is_wait),
    .wake       (wake),
    .in_wait    (in_wait),
    .core_sleep (core_sleep)
  );

  wfi_resume_pipe #(.RESUME_LAT(RESUME_LAT)) u_resume (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_wait      (in_wait),
    .fetch_en     (fetch_en),
    .dbg_mode     (dbg_mode),
    .fetch_resume (fetch_resume)
  );

  p_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wait && !wake) |=> in_wait);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !wake) |=> in_wait);
  p_resume_outside_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_resume |-> !in_wait);
endmodule

// File: tb/wfi_sleep_ctrl_tb.sv
module wfi_sleep_ctrl_tb;
  localparam logic [31:0] WFI = 32'h1050_0073;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        id_valid = 1'b0;
  logic [31:0] id_instr = '0;
  logic        ex_branch_taken = 1'b0;
  logic [31:0] irq_pend_en = '0;
  logic        dbg_req = 1'b0;
  logic        dbg_mode = 1'b0;
  logic        fetch_en = 1'b1;
  logic        in_wait, core_sleep, fetch_resume;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  wfi_sleep_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_instr(id_instr),
    .ex_branch_taken(ex_branch_taken), .irq_pend_en(irq_pend_en),
    .dbg_req(dbg_req), .dbg_mode(dbg_mode), .fetch_en(fetch_en),
    .in_wait(in_wait), .core_sleep(core_sleep), .fetch_resume(fetch_resume)
  );

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic outs(string req, logic w, logic s, logic r);
    chk(req, "in_wait", in_wait, w);
    chk(req, "core_sleep", core_sleep, s);
    chk(req, "fetch_resume", fetch_resume, r);
  endtask

  // Present the wait word for one edge; returns after that edge.
  task automatic issue(logic [31:0] word, logic vld, logic br);
    id_valid = vld; id_instr = word; ex_branch_taken = br;
    tick();
    id_valid = 1'b0; id_instr = '0; ex_branch_taken = 1'b0;
  endtask

  task automatic settle();
    irq_pend_en = '0; dbg_req = 1'b0; dbg_mode = 1'b0; fetch_en = 1'b1;
    tick(4);
  endtask

  task automatic t_reset();
    tick(3);
    outs("R1", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    tick();
    outs("R1", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_decode_filter();
    issue(WFI ^ 32'h1, 1'b1, 1'b0);         chk("R2", "bit0 flip", in_wait, 1'b0);
    issue(WFI ^ 32'h0010_0000, 1'b1, 1'b0); chk("R2", "bit20 flip", in_wait, 1'b0);
    issue(WFI ^ 32'h8000_0000, 1'b1, 1'b0); chk("R2", "bit31 flip", in_wait, 1'b0);
    issue(WFI, 1'b0, 1'b0);                 chk("R2", "valid low", in_wait, 1'b0);
  endtask

  task automatic t_branch_cancel();
    issue(WFI, 1'b1, 1'b1);
    chk("R3", "cancelled", in_wait, 1'b0);
    tick(6);
    chk("R3", "no sleep", core_sleep, 1'b0);
  endtask

  // Full wait, sleep, wake via interrupt bit or debug request.
  task automatic t_full(int bit_idx, logic use_dbg);
    issue(WFI, 1'b1, 1'b0);
    outs("R4", 1'b1, 1'b0, 1'b0);
    tick(5);
    chk("R6", "sleep before delay", core_sleep, 1'b0);
    tick();
    chk("R6", "sleep at delay", core_sleep, 1'b1);
    tick(3);
    chk("R6", "sleep held", core_sleep, 1'b1);
    if (use_dbg) dbg_req = 1'b1; else irq_pend_en[bit_idx] = 1'b1;
    tick();
    outs("R7", 1'b0, 1'b0, 1'b0);
    dbg_req = 1'b0; irq_pend_en = '0;
    tick();
    chk("R8", "resume early", fetch_resume, 1'b0);
    tick();
    chk("R8", "resume pulse", fetch_resume, 1'b1);
    tick();
    chk("R8", "resume one cycle", fetch_resume, 1'b0);
    settle();
  endtask

  task automatic t_early_wake();
    issue(WFI, 1'b1, 1'b0);
    tick(4);
    irq_pend_en[16] = 1'b1;
    tick();
    outs("R6", 1'b0, 1'b0, 1'b0);
    irq_pend_en = '0;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk("R6", "no sleep after early wake", core_sleep, 1'b0);
    end
    settle();
  endtask

  // Wake lands on the edge where sleep would otherwise rise.
  task automatic t_wake_at_delay();
    issue(WFI, 1'b1, 1'b0);
    tick(5);
    irq_pend_en[3] = 1'b1;
    tick();
    outs("R6", 1'b0, 1'b0, 1'b0);
    settle();
  endtask

  task automatic t_collision();
    irq_pend_en[7] = 1'b1;
    issue(WFI, 1'b1, 1'b0);
    chk("R5", "irq blocks entry", in_wait, 1'b0);
    irq_pend_en = '0;
    dbg_req = 1'b1;
    issue(WFI, 1'b1, 1'b0);
    chk("R5", "dbg_req blocks entry", in_wait, 1'b0);
    dbg_req = 1'b0;
    tick(6);
    chk("R5", "no sleep after collision", core_sleep, 1'b0);
  endtask

  task automatic t_gated_resume(logic fe, logic dm);
    issue(WFI, 1'b1, 1'b0);
    tick(6);
    fetch_en = fe; dbg_mode = dm;
    irq_pend_en[31] = 1'b1;
    tick();
    chk("R8", "wake", in_wait, 1'b0);
    irq_pend_en = '0;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R8", "resume suppressed", fetch_resume, 1'b0);
    end
    settle();
  endtask

  task automatic t_dbg_mode_hold();
    issue(WFI, 1'b1, 1'b0);
    tick(6);
    dbg_mode = 1'b1;
    tick(3);
    chk("R9", "wait held", in_wait, 1'b1);
    chk("R9", "sleep held", core_sleep, 1'b1);
    dbg_mode = 1'b0;
    dbg_req = 1'b1;
    tick();
    chk("R5", "dbg_req wakes", in_wait, 1'b0);
    settle();
  endtask

  initial begin
    t_reset();
    t_decode_filter();
    t_branch_cancel();
    t_full(11, 1'b0);
    t_full(0, 1'b1);
    t_full(20, 1'b0);
    t_early_wake();
    t_wake_at_delay();
    t_collision();
    t_gated_resume(1'b0, 1'b0);
    t_gated_resume(1'b1, 1'b1);
    t_dbg_mode_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule